// File: doc/BRIEF.md
# Segment Descriptor Protection Checker

This block turns a logical memory access, given as a selector and a 32-bit offset, into a 32-bit linear address. It checks the access against a 64-bit protected-mode segment descriptor taken from a small internal table. The table is filled through a write port that writes one entry per cycle. Each request carries its selector, its offset, an access kind (instruction fetch, data read or data write) and the current privilege level of the requester.

The descriptor fields that are scattered across the entry are put back together inside the block. The 32-bit base comes from three pieces and the 20-bit limit from two. The limit is optionally scaled to 4 KB units, and expand-down data segments invert the bound test. The block checks presence, privilege, segment type and access rights. It then returns either the linear address or a fault with a 3-bit cause code. Results appear in registers one cycle after the request, together with a valid strobe.

Top module: `seg_prot_unit`

## Requirements
- R1: A request accepted on a rising edge with `req_valid` high produces `rsp_valid` high after that edge for exactly one cycle per request. `rsp_valid` is low in any cycle that follows an edge where `req_valid` was low, including right after reset.
- R2: A table entry is written on a rising edge with `tbl_we` high. The entry holds limit[15:0] in bits 15:0, base[15:0] in 31:16, base[23:16] in 39:32, the access byte in 47:40, limit[19:16] in 51:48, the flags nibble in 55:52 (bit 55 granularity, bit 54 operand size) and base[31:24] in 63:56. Reset clears every entry to zero. A lookup reads the content held before the current edge.
- R3: The table index is the selector divided by 8, so selector bits 2:0 are ignored. Index 0 is the null segment, and any access through it faults with cause 1.
- R4: If the access byte present bit (bit 7) is 0, the access faults with cause 2.
- R5: The descriptor privilege sits in access bits 6:5. If the requester privilege number is greater than the descriptor privilege number, the access faults with cause 3. This applies to data segments and to code segments whose bit 2 (conforming) is clear. Conforming code is exempt.
- R6: Access kinds are encoded as 0 fetch, 1 read and 2 write, with 3 treated as a read. An access faults with cause 4 in any of these cases:
  - the descriptor bit 4 is 0 (a system descriptor);
  - a fetch from a segment whose bit 3 (executable) is clear;
  - a write to any executable segment;
  - a write to a data segment whose bit 1 is clear;
  - a read from code whose bit 1 is clear.
  Reads from data segments are always allowed.
- R7: With granularity 0 the limit counts bytes. An upward segment accepts an offset when offset <= limit and otherwise faults with cause 5.
- R8: With granularity 1 the effective limit is {limit, 12'hFFF}.
- R9: A data segment with bit 2 set grows downward. It accepts offsets strictly above the effective limit and faults with cause 5 otherwise.
- R10: On success, `rsp_fault` is 0, `rsp_cause` is 0 and `rsp_lin` is base + offset modulo 2^32. On a fault, `rsp_fault` is 1 and `rsp_lin` is 0.
- R11: When several faults apply, the lowest cause wins: null (1), then not present (2), then privilege (3), then type/rights (4), then limit (5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Descriptor table write enable |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_data | input | 64 | Descriptor written to the entry |
| req_valid | input | 1 | Request strobe |
| req_sel | input | SEL_W | Selector (byte offset into the table) |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| req_cpl | input | 2 | Current privilege level of the requester |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 3 | Fault cause, 0 when no fault |
| rsp_lin | output | 32 | Linear address, 0 on a fault |

## Verification
The bench builds the block with the default of eight table entries. This puts the top index within reach alongside the null entry, so every slot can be filled with a distinct segment kind. Entries are rewritten mid-run to reach conforming code and system descriptors. The vectors place offsets exactly on and one past each bound, for both granularities and for expand-down. They also wrap the base-plus-offset sum past 2^32 and stack several fault conditions on one access to expose the priority order.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CZ_NONE   = 3'd0,
        CZ_NULL   = 3'd1,
        CZ_ABSENT = 3'd2,
        CZ_PRIV   = 3'd3,
        CZ_TYPE   = 3'd4,
        CZ_LIMIT  = 3'd5
    } fault_cause_e;

    // Decoded view of one descriptor
    typedef struct packed {
        logic [31:0] base;
        logic [19:0] limit;
        logic        gran;
        logic        big;
        logic        present;
        logic [1:0]  dpl;
        logic        nonsys;
        logic        exec;
        logic        dc;
        logic        rw;
    } seg_view_t;

    function automatic seg_view_t unpack_desc(input logic [63:0] d);
        seg_view_t v;
        v.base    = {d[63:56], d[39:32], d[31:16]};
        v.limit   = {d[51:48], d[15:0]};
        v.gran    = d[55];
        v.big     = d[54];
        v.present = d[47];
        v.dpl     = d[46:45];
        v.nonsys  = d[44];
        v.exec    = d[43];
        v.dc      = d[42];
        v.rw      = d[41];
        return v;
    endfunction

    function automatic logic [31:0] scale_limit(input logic [19:0] lim, input logic g);
        return g ? {lim, 12'hFFF} : {12'h000, lim};
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
    parameter int ENTRY_CNT = 8,
    localparam int IDX_W = $clog2(ENTRY_CNT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_data
);
    logic [63:0] entry_q [ENTRY_CNT];

    for (genvar gi = 0; gi < ENTRY_CNT; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                entry_q[gi] <= wr_data;
            end
        end
    end

    assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
    import seg_chk_pkg::*;
(
    input  seg_view_t    view,
    input  logic         is_null,
    input  acc_kind_e    kind,
    input  logic [1:0]   cpl,
    input  logic [31:0]  offset,
    output fault_cause_e cause,
    output logic [31:0]  lin
);
    logic [31:0] eff_lim;
    logic        grows_down;
    logic        priv_bad;
    logic        type_bad;
    logic        lim_bad;
    logic        is_write;
    logic        is_fetch;

    always_comb begin
        eff_lim    = scale_limit(view.limit, view.gran);
        grows_down = !view.exec && view.dc;
        is_write   = (kind == ACC_WRITE);
        is_fetch   = (kind == ACC_FETCH);

        // Conforming code skips the privilege comparison
        priv_bad = (cpl > view.dpl) && !(view.exec && view.dc);

        type_bad = !view.nonsys
                 || (is_fetch && !view.exec)
                 || (is_write && view.exec)
                 || (is_write && !view.exec && !view.rw)
                 || (!is_write && !is_fetch && view.exec && !view.rw);

        lim_bad = grows_down ? (offset <= eff_lim) : (offset > eff_lim);

        if (is_null)              cause = CZ_NULL;
        else if (!view.present)   cause = CZ_ABSENT;
        else if (priv_bad)        cause = CZ_PRIV;
        else if (type_bad)        cause = CZ_TYPE;
        else if (lim_bad)         cause = CZ_LIMIT;
        else                      cause = CZ_NONE;

        lin = view.base + offset;
    end
endmodule

// File: rtl/seg_prot_unit.sv
module seg_prot_unit
    import seg_chk_pkg::*;
#(
    parameter int ENTRY_CNT = 8,
    localparam int IDX_W = $clog2(ENTRY_CNT),
    localparam int SEL_W = IDX_W + 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [63:0]      tbl_data,
    input  logic             req_valid,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [31:0]      req_off,
    input  logic [1:0]       req_kind,
    input  logic [1:0]       req_cpl,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [2:0]       rsp_cause,
    output logic [31:0]      rsp_lin
);
    logic [IDX_W-1:0] look_idx;
    logic [63:0]      raw_desc;
    seg_view_t        view;
    fault_cause_e     chk_cause;
    logic [31:0]      chk_lin;

    assign look_idx = req_sel[SEL_W-1:3];

    seg_desc_table #(.ENTRY_CNT(ENTRY_CNT)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_data (tbl_data),
        .rd_idx  (look_idx),
        .rd_data (raw_desc)
    );

    assign view = unpack_desc(raw_desc);

    seg_rights_check u_check (
        .view    (view),
        .is_null (look_idx == '0),
        .kind    (acc_kind_e'(req_kind)),
        .cpl     (req_cpl),
        .offset  (req_off),
        .cause   (chk_cause),
        .lin     (chk_lin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            rsp_lin   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= (chk_cause != CZ_NONE);
                rsp_cause <= chk_cause;
                rsp_lin   <= (chk_cause == CZ_NONE) ? chk_lin : 32'h0;
            end
        end
    end
endmodule

// File: rtl/seg_prot_checker.sv
module seg_prot_checker #(
    parameter int SEL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [SEL_W-1:0] req_sel,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [2:0]       rsp_cause,
    input logic [31:0]      rsp_lin
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r3_null_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_sel[SEL_W-1:3] == '0) |=> (rsp_fault && rsp_cause == 3'd1));

    a_r10_lin_cleared: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_lin == 32'h0));

    a_r10_cause_agrees: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

    a_r11_cause_range: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_cause <= 3'd5));
endmodule

bind seg_prot_unit seg_prot_checker #(.SEL_W(SEL_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_lin   (rsp_lin)
);

// File: tb/test_seg_prot_unit.sv
module test_seg_prot_unit;
    localparam int ENTRY_CNT = 8;
    localparam int IDX_W = $clog2(ENTRY_CNT);
    localparam int SEL_W = IDX_W + 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tbl_we = 1'b0;
    logic [IDX_W-1:0] tbl_idx = '0;
    logic [63:0]      tbl_data = '0;
    logic             req_valid = 1'b0;
    logic [SEL_W-1:0] req_sel = '0;
    logic [31:0]      req_off = '0;
    logic [1:0]       req_kind = '0;
    logic [1:0]       req_cpl = '0;
    logic             rsp_valid;
    logic             rsp_fault;
    logic [2:0]       rsp_cause;
    logic [31:0]      rsp_lin;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [34:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    seg_prot_unit #(.ENTRY_CNT(ENTRY_CNT)) i_seg_prot_unit (
        .clk(clk), .rst(rst),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
        .req_kind(req_kind), .req_cpl(req_cpl),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_lin(rsp_lin)
    );

    // Packs fields into the entry layout stated in R2
    function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                       input logic [7:0] acc, input logic [3:0] flg);
        return {base[31:24], flg, lim[19:16], acc, base[23:16], base[15:0], lim[15:0]};
    endfunction

    task automatic wr(input int idx, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        tbl_we    = 1'b1;
        tbl_idx   = IDX_W'(idx);
        tbl_data  = d;
        @(negedge clk);
        tbl_we    = 1'b0;
    endtask

    // Drives one request and queues its expected result
    task automatic req(input int idx, input logic [31:0] off, input logic [1:0] kind,
                       input logic [1:0] cpl, input logic [2:0] cz,
                       input logic [31:0] lin, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_sel   = SEL_W'({idx[IDX_W-1:0], 3'b101});
        req_off   = off;
        req_kind  = kind;
        req_cpl   = cpl;
        exp_q.push_back({cz, (cz == 3'd0) ? lin : 32'h0});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            logic [34:0] e;
            string t;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1: unexpected result, actual valid=1 expected valid=0");
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_cause != e[34:32] || rsp_lin != e[31:0] ||
                    rsp_fault != (e[34:32] != 3'd0)) begin
                    n_bad++;
                    $display("FAIL %s: actual fault=%0d cause=%0d lin=%h expected cause=%0d lin=%h",
                             t, rsp_fault, rsp_cause, rsp_lin, e[34:32], e[31:0]);
                end
            end
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: reset valid actual %b expected 0", rsp_valid);
        end
        // R2: cleared table means entry 1 reads not present
        req(1, 32'h0, 2'd1, 2'd0, 3'd2, 32'h0, "R2 cleared entry");
        idle();

        wr(1, mk(32'h0001_0000, 20'h0FFFF, 8'h9A, 4'h4));
        wr(2, mk(32'h0002_0000, 20'h00FFF, 8'h92, 4'h4));
        wr(3, mk(32'hFFFF_F000, 20'h00001, 8'h92, 4'hC));
        wr(4, mk(32'h0000_1000, 20'h00FFF, 8'h96, 4'h4));
        wr(5, mk(32'h0000_0000, 20'hFFFFF, 8'h12, 4'h4));
        wr(6, mk(32'h0000_0000, 20'h000FF, 8'h90, 4'h4));
        wr(7, mk(32'h0000_0100, 20'h000FF, 8'h98, 4'h4));

        req(1, 32'h0000_1234, 2'd0, 2'd0, 3'd0, 32'h0001_1234, "R10 code fetch");
        req(1, 32'h0000_0010, 2'd1, 2'd0, 3'd0, 32'h0001_0010, "R6 readable code read");
        req(1, 32'h0001_0000, 2'd0, 2'd0, 3'd5, 32'h0, "R7 code past limit");
        req(1, 32'h0000_0000, 2'd2, 2'd0, 3'd4, 32'h0, "R6 write to code");
        req(2, 32'h0000_0FFF, 2'd2, 2'd0, 3'd0, 32'h0002_0FFF, "R7 offset equals limit");
        req(2, 32'h0000_1000, 2'd1, 2'd0, 3'd5, 32'h0, "R7 one past limit");
        req(2, 32'h0000_0000, 2'd0, 2'd0, 3'd4, 32'h0, "R6 fetch from data");
        req(3, 32'h0000_1FFF, 2'd1, 2'd0, 3'd0, 32'h0000_0FFF, "R8 scaled limit with R10 wrap");
        req(3, 32'h0000_2000, 2'd2, 2'd0, 3'd5, 32'h0, "R8 past scaled limit");
        req(4, 32'h0000_0FFF, 2'd1, 2'd0, 3'd5, 32'h0, "R9 expand-down at limit");
        req(4, 32'h0000_1000, 2'd2, 2'd0, 3'd0, 32'h0000_2000, "R9 expand-down above limit");
        req(4, 32'hFFFF_FFFF, 2'd1, 2'd0, 3'd0, 32'h0000_0FFF, "R9 expand-down top offset");
        req(5, 32'h0000_0000, 2'd1, 2'd0, 3'd2, 32'h0, "R4 not present");
        req(5, 32'h0000_0000, 2'd1, 2'd3, 3'd2, 32'h0, "R11 absent before privilege");
        req(0, 32'h0000_0000, 2'd1, 2'd0, 3'd1, 32'h0, "R3 null selector");
        req(6, 32'h0000_0080, 2'd1, 2'd0, 3'd0, 32'h0000_0080, "R6 read-only data read");
        req(6, 32'h0000_0080, 2'd2, 2'd0, 3'd4, 32'h0, "R6 write to read-only data");
        req(7, 32'h0000_0010, 2'd1, 2'd0, 3'd4, 32'h0, "R6 read of exec-only code");
        req(7, 32'h0000_0200, 2'd1, 2'd0, 3'd4, 32'h0, "R11 type before limit");
        req(7, 32'h0000_0010, 2'd0, 2'd0, 3'd0, 32'h0000_0110, "R6 exec-only fetch");
        req(2, 32'h0000_0010, 2'd1, 2'd3, 3'd3, 32'h0, "R5 data privilege");
        req(1, 32'h0000_0010, 2'd2, 2'd3, 3'd3, 32'h0, "R11 privilege before type");
        req(1, 32'h0000_0010, 2'd0, 2'd3, 3'd3, 32'h0, "R5 nonconforming code");
        idle();
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: idle valid actual %b expected 0", rsp_valid);
        end

        wr(7, mk(32'h0000_0100, 20'h000FF, 8'hDE, 4'h4));
        wr(6, mk(32'h0000_0000, 20'h000FF, 8'h82, 4'h4));
        req(7, 32'h0000_0020, 2'd0, 2'd3, 3'd0, 32'h0000_0120, "R5 conforming fetch");
        req(7, 32'h0000_0030, 2'd1, 2'd3, 3'd0, 32'h0000_0130, "R5 conforming read");
        req(6, 32'h0000_0000, 2'd1, 2'd0, 3'd4, 32'h0, "R6 system descriptor");
        idle();
        repeat (3) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: pending results actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
    end
endmodule